// File: doc/BRIEF.md
# Collision-Vector Start Controller

This block sits in front of a multi-function pipeline in which a task may visit the same stage more than once, and decides in every clock cycle whether a new task may enter without meeting an earlier task at a shared stage. The forbidden spacings are given to it as a collision vector on an input. It keeps a state word that marks the cycles in which a start would collide. The state moves one place each clock. On every accepted start, the collision vector is folded back into it.

A requester offers a start with `req_valid`, and the controller answers with `req_ready`. A start happens in a cycle where both are high. A request that arrives in a forbidden cycle is not lost: ready stays low until a cycle with no collision, and the start happens then. An optional paced mode admits starts only once a chosen spacing has elapsed, so a constant-latency schedule can be run. A start counter and a running sum of the spacings between starts let the average latency be read as `lat_sum / (start_count - 1)`.

Top module: `cvic_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `start_count`, `lat_sum` and `lat_now` are 0 and `permit` and `req_ready` are 1.
- R2: The first start after reset is accepted in the cycle it is requested, whatever the collision vector. Bit k of `coll_vec` set to 1 means that a start k+1 cycles after an earlier accepted start is forbidden.
- R3: `permit` is 0 in a cycle exactly when, for some earlier accepted start d cycles back with 1 <= d <= MAXLAT, bit d-1 of `coll_vec` is 1. Otherwise it is 1.
- R4: After each start the forbidden set is the old set advanced by the spacing used, merged with the collision vector. Because of this, a sequence of several starts never places two tasks d cycles apart for any forbidden d, including non-adjacent pairs.
- R5: A request in a cycle with `req_ready` low is held off: no start is counted in that cycle. It is accepted in the first later cycle in which `req_ready` is 1 while `req_valid` is still high.
- R6: `lat_now` is 0 before the first start. It is 1 in the cycle after a start, rises by 1 each cycle after that, and saturates at 2^LATW-1.
- R7: When `fixed_mode` is 1 and a start has already been made, `req_ready` also requires `lat_now >= fixed_lat`. With vector 1011010 and `fixed_lat` 3, a permanent request yields a constant cycle of latency 3.
- R8: `start_count` rises by exactly 1 in the cycle after each accepted start and is otherwise unchanged.
- R9: At every accepted start except the first, `lat_sum` grows by the `lat_now` of that cycle. It is otherwise unchanged. The constant cycle of R7 gives `lat_sum` = 3*(`start_count`-1), which is an average of 3.
- R10: With vector 1011010 (latencies 2, 4, 5 and 7 forbidden), a request held high from latency 2 onward is refused at latency 2 and accepted at latency 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coll_vec | input | MAXLAT | Collision vector; bit k forbids latency k+1 |
| fixed_mode | input | 1 | Paced mode enable |
| fixed_lat | input | LATW | Minimum spacing in paced mode |
| req_valid | input | 1 | Start request |
| req_ready | output | 1 | Start may be taken this cycle |
| permit | output | 1 | Current latency is free of collisions |
| lat_now | output | LATW | Cycles since the last accepted start |
| start_count | output | CNTW | Number of accepted starts |
| lat_sum | output | SUMW | Sum of spacings between accepted starts |

## Verification
`req_ready` and `permit` are combinational from the state and the current inputs, so they are due in the same cycle as the request. `lat_now`, `start_count` and `lat_sum` change one clock after an accepted start. The bench changes inputs on the falling edge and compares all five outputs 1 ns later. It then advances its own reference model across the next rising edge, so each registered result is compared in the cycle after the start that caused it. The model decides whether a start is allowed from a list of earlier start times and the collision vector alone. The collision vector is changed only after more than MAXLAT idle cycles and a reset.

// File: rtl/cvic_ctrl.sv
module cvic_ctrl #(
  parameter int MAXLAT = 7,
  parameter int LATW   = 8,
  parameter int CNTW   = 16,
  parameter int SUMW   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAXLAT-1:0] coll_vec,
  input  logic              fixed_mode,
  input  logic [LATW-1:0]   fixed_lat,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              permit,
  output logic [LATW-1:0]   lat_now,
  output logic [CNTW-1:0]   start_count,
  output logic [SUMW-1:0]   lat_sum
);
  localparam logic [LATW-1:0] LAT_TOP = {LATW{1'b1}};

  logic [MAXLAT-1:0] busy_q;
  logic              seen_q;
  logic [LATW-1:0]   lat_q;
  logic [CNTW-1:0]   cnt_q;
  logic [SUMW-1:0]   sum_q;
  logic              pace_ok;
  logic              fire;

  assign permit    = ~busy_q[0];
  assign pace_ok   = ~fixed_mode | ~seen_q | (lat_q >= fixed_lat);
  assign req_ready = permit & pace_ok;
  assign fire      = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      seen_q <= 1'b0;
      lat_q  <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
    end else begin
      busy_q <= fire ? ((busy_q >> 1) | coll_vec) : (busy_q >> 1);
      if (fire) begin
        seen_q <= 1'b1;
        lat_q  <= LATW'(1);
        cnt_q  <= cnt_q + CNTW'(1);
        if (seen_q) sum_q <= sum_q + SUMW'(lat_q);
      end else if (seen_q && lat_q != LAT_TOP) begin
        lat_q <= lat_q + LATW'(1);
      end
    end
  end

  assign lat_now     = lat_q;
  assign start_count = cnt_q;
  assign lat_sum     = sum_q;
endmodule

// File: rtl/cvic_ctrl_chk.sv
module cvic_ctrl_chk #(
  parameter int MAXLAT = 7,
  parameter int LATW   = 8,
  parameter int CNTW   = 16,
  parameter int SUMW   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MAXLAT-1:0] coll_vec,
  input logic              fixed_mode,
  input logic [LATW-1:0]   fixed_lat,
  input logic              req_valid,
  input logic              req_ready,
  input logic              permit,
  input logic [LATW-1:0]   lat_now,
  input logic [CNTW-1:0]   start_count,
  input logic [SUMW-1:0]   lat_sum
);
  logic took;
  assign took = req_valid & req_ready;

  // R6
  lat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> lat_now == LATW'(1));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> start_count == $past(start_count) + CNTW'(1));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> $stable(start_count));

  // R9
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> $stable(lat_sum));

  // R7
  pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && fixed_mode && start_count != '0) |-> lat_now >= fixed_lat);

  // R3
  next_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && coll_vec[0]) |=> !permit);

  // R5
  ready_needs_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> permit);
endmodule

bind cvic_ctrl cvic_ctrl_chk #(.MAXLAT(MAXLAT), .LATW(LATW), .CNTW(CNTW), .SUMW(SUMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .coll_vec(coll_vec), .fixed_mode(fixed_mode),
  .fixed_lat(fixed_lat), .req_valid(req_valid), .req_ready(req_ready),
  .permit(permit), .lat_now(lat_now), .start_count(start_count), .lat_sum(lat_sum));

// File: tb/sim_cvic_ctrl.sv
`timescale 1ns/1ps
module sim_cvic_ctrl;
  localparam int M = 7, LW = 8, CW = 16, SW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [M-1:0] coll_vec = '0;
  logic fixed_mode = 1'b0, req_valid = 1'b0;
  logic [LW-1:0] fixed_lat = '0;
  logic req_ready, permit;
  logic [LW-1:0] lat_now;
  logic [CW-1:0] start_count;
  logic [SW-1:0] lat_sum;

  always #10 clk = ~clk;

  cvic_ctrl #(.MAXLAT(M), .LATW(LW), .CNTW(CW), .SUMW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .coll_vec(coll_vec), .fixed_mode(fixed_mode),
    .fixed_lat(fixed_lat), .req_valid(req_valid), .req_ready(req_ready),
    .permit(permit), .lat_now(lat_now), .start_count(start_count), .lat_sum(lat_sum));

  int n_chk = 0, n_bad = 0;
  longint t_now = 0;
  longint hist [M];
  bit m_seen;
  int m_lat, m_cnt, m_sum;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_permit();
    for (int k = 0; k < M; k++) begin
      longint d = t_now - hist[k];
      if (d >= 1 && d <= M && coll_vec[d-1]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit exp_ready();
    bit pace = !fixed_mode || !m_seen || (m_lat >= int'(fixed_lat));
    return exp_permit() && pace;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < M; k++) hist[k] = -1000;
    m_seen = 0; m_lat = 0; m_cnt = 0; m_sum = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "count in reset", start_count, 0);
    chk("R1", "sum in reset", lat_sum, 0);
    chk("R1", "lat in reset", lat_now, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one cycle, compare outputs, then advance the model across the edge.
  task automatic step(bit v, string tag);
    bit er, fire;
    @(negedge clk);
    req_valid = v;
    #1;
    er = exp_ready();
    chk(tag, "req_ready", req_ready, er);
    chk("R3", "permit", permit, exp_permit());
    chk("R6", "lat_now", lat_now, m_lat);
    chk("R8", "start_count", start_count, m_cnt);
    chk("R9", "lat_sum", lat_sum, m_sum);
    fire = v && er;
    if (fire) begin
      if (m_seen) m_sum += m_lat;
      m_cnt++;
      for (int k = M-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = t_now;
      m_seen = 1; m_lat = 1;
    end else if (m_seen && m_lat != 255) m_lat++;
    t_now++;
  endtask

  bit wd_hit = 0;
  initial begin
    #(20ns * 190000);
    wd_hit = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20140122);
    model_reset();
    coll_vec = 7'b1011010;
    do_reset();
    #1;
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "permit after reset", permit, 1);

    // R2: first start accepted at once
    step(1, "R2");
    chk("R2", "first start", m_cnt, 1);
    // R10: idle at latency 1, request from latency 2
    step(0, "R5");
    step(1, "R10");
    step(1, "R10");
    chk("R10", "started at latency 3", m_sum, 3);
    repeat (12) step(1, "R4");
    repeat (10) step(0, "R4");

    // R7 / R9: constant cycle of 3
    do_reset();
    fixed_mode = 1'b1; fixed_lat = 8'd3;
    repeat (40) step(1, "R7");
    #1;
    chk("R9", "average 3", lat_sum, 3 * (start_count - 1));
    chk("R7", "starts in constant cycle", start_count > 10, 1);

    // R7: fixed latency 2 forbidden, starts slip to 3
    do_reset();
    fixed_lat = 8'd2;
    repeat (20) step(1, "R7");
    fixed_mode = 1'b0;

    // R6: saturation
    do_reset();
    step(1, "R6");
    repeat (300) step(0, "R6");
    #1;
    chk("R6", "saturated lat", lat_now, 255);
    step(1, "R9");

    // Random phases
    for (int ph = 0; ph < 40; ph++) begin
      repeat (M + 1) step(0, "R5");
      coll_vec = M'($urandom);
      fixed_mode = ($urandom % 3) == 0;
      fixed_lat = LW'($urandom % 9);
      do_reset();
      for (int c = 0; c < 300; c++) step(($urandom % 10) < 6, "R5");
    end

    if (!wd_hit) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule